// File: doc/BRIEF.md
# MDIO Management User-Access Controller

This block carries out a single clause-22 management transaction on a two-wire PHY management bus each time software launches one. Software programs an enable and a clock divider in a control register. It then writes one access register that holds the operation (read or write), the PHY address, the PHY register number and, for writes, the 16-bit payload. Setting the launch bit in that same write starts the frame. The controller generates the management clock, shifts the frame out on the data line with an output enable, and releases the line for the turnaround and data phases of a read.

The access register also returns the result. The launch bit stays set while the frame is in flight and clears itself when the frame ends. On a read, an acknowledge bit reports whether the PHY pulled the line low during the turnaround. The data field then holds the 16 bits the PHY returned. Software polls either the launch bit or the idle bit of the control register to learn when the transaction has finished.

Top module: `mdio_user_access`

## Requirements
- R1: After reset the control register reads idle = 1, enable = 0 and divider = 0, the access register reads all zeros, and the management clock and output enable are both low.
- R2: Register layout. Address 0 is the control register: bit 31 is idle (read only), bit 30 is enable, and bits DIV_W-1:0 hold the divider. Address 1 is the access register: bit 31 is go, bit 30 selects write (1) or read (0), bit 29 is acknowledge (read only), bits 25:21 hold the register number, bits 20:16 hold the PHY address, and bits 15:0 hold the data.
- R3: A write to the access register with bit 31 set, while the block is enabled and idle, starts a transaction. From then on go reads 1 and idle reads 0 until the frame ends, and then go clears by itself.
- R4: A frame is exactly 64 management-clock periods long, with one bit per period, sent MSB first and sampled at the rising clock edge. Its fields are: PREAMBLE_BITS ones, start 01, opcode (10 for read, 01 for write), the 5-bit PHY address, the 5-bit register number, turnaround 10 on writes, and then the 16 data bits.
- R5: The management clock has a period of 2*(divider+1) system clocks during a frame and stays low whenever no frame is in flight.
- R6: On a write, the output enable is high for all 64 bits. On a read, it is high for the first 46 bits and low from the first turnaround bit to the end of the frame.
- R7: A read sets acknowledge to 1 only if the data line is low at the rising edge of the second turnaround bit. In that case, data bits 15:0 take the 16 bits sampled on the following 16 rising edges, MSB first. A completed write leaves acknowledge at 0, and every launch clears acknowledge.
- R8: A read without acknowledge leaves the data field at the value it held when the read was launched.
- R9: Writes to the access register while go is set are ignored. The fields and the frame in flight do not change, and no second frame follows.
- R10: While enable is 0, a write with bit 31 set stores the fields but does not set go and produces no management clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 control, 1 access |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Contents of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Management data driven toward the PHY |
| mdioOe | output | 1 | Output enable for mdioOut |
| mdioIn | input | 1 | Management data sampled from the PHY |

## Verification
The bench builds the block with DIV_W = 4 and the default 32-bit preamble. With a 4-bit divider, the largest divider value (15, giving a 32-clock period) can be reached within a short run, and so can the smallest value (0, giving a 2-clock period). A PHY model in the bench counts rising clock edges from each launch. It records the bit and output enable seen at each edge, and can answer a read with a chosen acknowledge and data word. This lets the bench compare complete frames bit by bit and exercise both the acknowledged and the silent read paths.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  // control-to-datapath strobes
  typedef struct packed {
    logic load;     // capture a new frame, restart clock phase
    logic run;      // a frame is in flight
    logic capAck;   // sample turnaround response at the next rising edge
    logic capData;  // shift read data in at the next rising edge
  } mdioStrobe_t;

  localparam int ACC_GO  = 31;
  localparam int ACC_WR  = 30;
  localparam int ACC_ACK = 29;
  localparam int CTL_IDLE = 31;
  localparam int CTL_EN   = 30;
endpackage

// File: rtl/mdio_dp.sv
`timescale 1ns/1ps
module mdio_dp
  import mdio_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int FRAME_BITS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  mdioStrobe_t       strb,
  input  logic [DIV_W-1:0]  divVal,
  input  logic [FRAME_BITS-1:0] frameIn,
  input  logic              mdioIn,
  output logic              mdc,
  output logic              mdioBit,
  output logic              fallTick,
  output logic [15:0]       capWord,
  output logic              ackSeen
);
  logic [DIV_W-1:0]      halfCnt;
  logic [FRAME_BITS-1:0] frameSh;
  logic                  halfDone;
  logic                  riseTick;

  assign halfDone = strb.run && (halfCnt >= divVal);
  assign riseTick = halfDone && !mdc;
  assign fallTick = halfDone && mdc;
  assign mdioBit  = frameSh[FRAME_BITS-1];

  // clock divider and frame shifter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfCnt <= '0;
      mdc     <= 1'b0;
      frameSh <= '0;
    end else if (strb.load) begin
      halfCnt <= '0;
      mdc     <= 1'b0;
      frameSh <= frameIn;
    end else if (strb.run) begin
      if (halfDone) begin
        halfCnt <= '0;
        mdc     <= !mdc;
        if (mdc) frameSh <= {frameSh[FRAME_BITS-2:0], 1'b0};
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
    end else begin
      halfCnt <= '0;
      mdc     <= 1'b0;
    end
  end

  // read-side capture on rising edges
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capWord <= '0;
      ackSeen <= 1'b0;
    end else if (strb.load) begin
      ackSeen <= 1'b0;
    end else begin
      if (strb.capAck && riseTick)  ackSeen <= !mdioIn;
      if (strb.capData && riseTick) capWord <= {capWord[14:0], mdioIn};
    end
  end
endmodule

// File: rtl/mdio_ctrl.sv
`timescale 1ns/1ps
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W         = 8,
  parameter int PREAMBLE_BITS = 32,
  parameter int FRAME_BITS    = PREAMBLE_BITS + 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              fallTick,
  input  logic [15:0]       capWord,
  input  logic              ackSeen,
  output mdioStrobe_t       strb,
  output logic [DIV_W-1:0]  divVal,
  output logic [FRAME_BITS-1:0] frameOut,
  output logic              mdioOe
);
  localparam int IDX_W   = $clog2(FRAME_BITS);
  localparam int TA1_IDX = FRAME_BITS - 18;
  localparam int TA2_IDX = FRAME_BITS - 17;
  localparam int D0_IDX  = FRAME_BITS - 16;

  logic             enable;
  logic [DIV_W-1:0] divQ;
  logic             busy;
  logic             isWrite;
  logic [4:0]       regNum;
  logic [4:0]       phyAddr;
  logic [15:0]      dataQ;
  logic             ackQ;
  logic [IDX_W-1:0] bitIdx;

  logic accWr, startReq, lastFall, gotAck;

  assign accWr    = regWrEn && regAddr;
  assign startReq = accWr && !busy && regWrData[ACC_GO] && enable;
  assign lastFall = fallTick && (bitIdx == IDX_W'(FRAME_BITS - 1));
  assign gotAck   = !isWrite && ackSeen;
  assign divVal   = divQ;

  assign frameOut = {{PREAMBLE_BITS{1'b1}}, 2'b01,
                     (regWrData[ACC_WR] ? 2'b01 : 2'b10),
                     regWrData[20:16], regWrData[25:21], 2'b10,
                     regWrData[15:0]};

  assign strb.load    = startReq;
  assign strb.run     = busy;
  assign strb.capAck  = busy && !isWrite && (bitIdx == IDX_W'(TA2_IDX));
  assign strb.capData = busy && !isWrite && (bitIdx >= IDX_W'(D0_IDX));
  assign mdioOe       = busy && (isWrite || (bitIdx < IDX_W'(TA1_IDX)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable <= 1'b0;
      divQ   <= '0;
    end else if (regWrEn && !regAddr) begin
      enable <= regWrData[CTL_EN];
      divQ   <= regWrData[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      isWrite <= 1'b0;
      regNum  <= '0;
      phyAddr <= '0;
      dataQ   <= '0;
      ackQ    <= 1'b0;
      bitIdx  <= '0;
    end else begin
      if (accWr && !busy) begin
        isWrite <= regWrData[ACC_WR];
        regNum  <= regWrData[25:21];
        phyAddr <= regWrData[20:16];
        dataQ   <= regWrData[15:0];
      end
      if (startReq) begin
        busy   <= 1'b1;
        bitIdx <= '0;
        ackQ   <= 1'b0;
      end else if (busy && fallTick) begin
        if (lastFall) begin
          busy <= 1'b0;
          ackQ <= gotAck;
          if (gotAck) dataQ <= capWord;
        end else begin
          bitIdx <= bitIdx + 1'b1;
        end
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr) begin
      regRdData[ACC_GO]  = busy;
      regRdData[ACC_WR]  = isWrite;
      regRdData[ACC_ACK] = ackQ;
      regRdData[25:21]   = regNum;
      regRdData[20:16]   = phyAddr;
      regRdData[15:0]    = dataQ;
    end else begin
      regRdData[CTL_IDLE]      = !busy;
      regRdData[CTL_EN]        = enable;
      regRdData[DIV_W-1:0]     = divQ;
    end
  end
endmodule

// File: rtl/mdio_user_access.sv
`timescale 1ns/1ps
module mdio_user_access
  import mdio_pkg::*;
#(
  parameter int DIV_W         = 8,
  parameter int PREAMBLE_BITS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  localparam int FRAME_BITS = PREAMBLE_BITS + 32;

  mdioStrobe_t           strb;
  logic [DIV_W-1:0]      divVal;
  logic [FRAME_BITS-1:0] frame;
  logic                  fallTick;
  logic [15:0]           capWord;
  logic                  ackSeen;
  logic                  mdioBit;

  mdio_ctrl #(.DIV_W(DIV_W), .PREAMBLE_BITS(PREAMBLE_BITS), .FRAME_BITS(FRAME_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .fallTick(fallTick),
    .capWord(capWord), .ackSeen(ackSeen), .strb(strb), .divVal(divVal),
    .frameOut(frame), .mdioOe(mdioOe)
  );

  mdio_dp #(.DIV_W(DIV_W), .FRAME_BITS(FRAME_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .divVal(divVal), .frameIn(frame),
    .mdioIn(mdioIn), .mdc(mdc), .mdioBit(mdioBit), .fallTick(fallTick),
    .capWord(capWord), .ackSeen(ackSeen)
  );

  assign mdioOut = mdioOe & mdioBit;
endmodule

// File: rtl/mdio_checker.sv
`timescale 1ns/1ps
module mdio_checker (
  input logic       clk,
  input logic       rstN,
  input logic       mdc,
  input logic       mdioOe,
  input logic       busy,
  input logic       enable,
  input logic       isWrite,
  input logic       ackQ,
  input logic [4:0] phyAddr
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe)); // R5

  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(enable)); // R10

  AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(phyAddr) && $stable(isWrite))); // R9

  AST_START_CLEARS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !ackQ); // R7

  AST_WRITE_NO_ACK: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && isWrite) |-> !ackQ); // R7
endmodule

bind mdio_user_access mdio_checker u_chk (
  .clk(clk), .rstN(rstN), .mdc(mdc), .mdioOe(mdioOe),
  .busy(u_ctrl.busy), .enable(u_ctrl.enable), .isWrite(u_ctrl.isWrite),
  .ackQ(u_ctrl.ackQ), .phyAddr(u_ctrl.phyAddr)
);

// File: tb/sim_mdio_user_access.sv
`timescale 1ns/1ps
module sim_mdio_user_access;
  localparam int DIV_W = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regAddr = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  mdio_user_access #(.DIV_W(DIV_W), .PREAMBLE_BITS(32)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always #4 clk = !clk;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  // PHY model: counts rising mdc edges since launch
  int          riseCnt = 0;
  logic [63:0] seenBits, seenOe;
  bit          phyAnswer = 0;
  logic [15:0] phyData = '0;
  int          clkCount = 0;
  int          lastRise = 0;
  int          period = 0;

  always @(posedge clk) clkCount++;

  always @(posedge mdc) begin
    if (riseCnt < 64) begin
      seenBits[63-riseCnt] = mdioOut;
      seenOe[63-riseCnt]   = mdioOe;
    end
    if (riseCnt > 0) period = clkCount - lastRise;
    lastRise = clkCount;
    riseCnt++;
    if (phyAnswer && riseCnt == 47) mdioIn = 1'b0;
    else if (phyAnswer && riseCnt >= 48 && riseCnt <= 63) mdioIn = phyData[63-riseCnt];
    else mdioIn = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic regWr(input logic a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRd(input logic a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitIdle();
    logic [31:0] d;
    for (int i = 0; i < 20000; i++) begin
      regRd(1'b1, d);
      if (!d[31]) break;
    end
  endtask

  task automatic launch(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                        input logic [15:0] dat);
    logic [31:0] d;
    riseCnt = 0;
    mdioIn = 1'b1;
    regWr(1'b1, {1'b1, wr, 1'b0, 3'b000, rg, phy, dat});
    regRd(1'b1, d);
    chk(d[31] == 1'b1, "R3", "go after launch", d[31], 1);
    regRd(1'b0, d);
    chk(d[31] == 1'b0, "R3", "idle during frame", d[31], 0);
    waitIdle();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    regRd(1'b0, d);
    chk(d == 32'h8000_0000, "R1", "control after reset", d, 32'h8000_0000);
    regRd(1'b1, d);
    chk(d == 32'h0, "R1", "access after reset", d, 0);
    chk(!mdc && !mdioOe, "R1", "pins after reset", {mdc, mdioOe}, 0);
  endtask

  task automatic t_write();
    logic [31:0] d;
    logic [63:0] expF;
    regWr(1'b0, 32'h4000_0002);
    phyAnswer = 0;
    launch(1'b1, 5'h11, 5'h04, 16'hA5C3);
    expF = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h11, 5'h04, 2'b10, 16'hA5C3};
    chk(riseCnt == 64, "R4", "write edge count", riseCnt, 64);
    chk(seenBits == expF, "R4", "write frame", seenBits, expF);
    chk(seenOe == '1, "R6", "write oe", seenOe, 64'hFFFF_FFFF_FFFF_FFFF);
    chk(period == 6, "R5", "period div2", period, 6);
    regRd(1'b1, d);
    chk(d == {3'b010, 3'b000, 5'h04, 5'h11, 16'hA5C3}, "R2", "write readback", d,
        {3'b010, 3'b000, 5'h04, 5'h11, 16'hA5C3});
    chk(d[29] == 1'b0, "R7", "write ack", d[29], 0);
    chk(!mdc && !mdioOe, "R5", "pins after frame", {mdc, mdioOe}, 0);
  endtask

  task automatic t_read_ack(input logic [DIV_W-1:0] dv, input logic [15:0] pd);
    logic [31:0] d;
    regWr(1'b0, 32'h4000_0000 | 32'(dv));
    phyAnswer = 1; phyData = pd;
    launch(1'b0, 5'h0A, 5'h1F, 16'h0000);
    chk(seenBits[63:18] == {32'hFFFF_FFFF, 2'b01, 2'b10, 5'h0A, 5'h1F}, "R4", "read header",
        {18'h0, seenBits[63:18]}, {18'h0, 32'hFFFF_FFFF, 2'b01, 2'b10, 5'h0A, 5'h1F});
    chk(seenOe == {{46{1'b1}}, 18'h0}, "R6", "read oe", seenOe, {{46{1'b1}}, 18'h0});
    chk(period == 2 * (int'(dv) + 1), "R5", "read period", period, 2 * (int'(dv) + 1));
    regRd(1'b1, d);
    chk(d[29] == 1'b1, "R7", "read ack", d[29], 1);
    chk(d[15:0] == pd, "R7", "read data", d[15:0], pd);
    phyAnswer = 0;
  endtask

  task automatic t_read_noack();
    logic [31:0] d;
    regWr(1'b0, 32'h4000_0001);
    phyAnswer = 0;
    launch(1'b0, 5'h02, 5'h03, 16'h1234);
    regRd(1'b1, d);
    chk(d[29] == 1'b0, "R8", "silent read ack", d[29], 0);
    chk(d[15:0] == 16'h1234, "R8", "silent read data kept", d[15:0], 16'h1234);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] d;
    logic [63:0] expF;
    regWr(1'b0, 32'h4000_0003);
    phyAnswer = 0; riseCnt = 0; mdioIn = 1'b1;
    regWr(1'b1, {3'b110, 3'b000, 5'h07, 5'h03, 16'hBEEF});
    repeat (50) @(negedge clk);
    regWr(1'b1, {3'b100, 3'b000, 5'h1F, 5'h1F, 16'h0000});
    waitIdle();
    expF = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h03, 5'h07, 2'b10, 16'hBEEF};
    chk(seenBits == expF, "R9", "frame untouched", seenBits, expF);
    regRd(1'b1, d);
    chk(d[30:0] == {2'b10, 3'b000, 5'h07, 5'h03, 16'hBEEF}, "R9", "fields untouched",
        d[30:0], {2'b10, 3'b000, 5'h07, 5'h03, 16'hBEEF});
    repeat (300) @(negedge clk);
    chk(riseCnt == 64, "R9", "no second frame", riseCnt, 64);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    regWr(1'b0, 32'h0000_0001);
    riseCnt = 0;
    regWr(1'b1, {3'b100, 3'b000, 5'h02, 5'h09, 16'h0055});
    regRd(1'b1, d);
    chk(d[31] == 1'b0, "R10", "go stays clear", d[31], 0);
    chk(d[20:16] == 5'h09 && d[15:0] == 16'h0055, "R10", "fields stored",
        {d[20:16], d[15:0]}, {5'h09, 16'h0055});
    repeat (200) @(negedge clk);
    chk(riseCnt == 0 && !mdc, "R10", "no clock edges", riseCnt, 0);
    regRd(1'b0, d);
    chk(d == 32'h8000_0001, "R2", "control readback", d, 32'h8000_0001);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_write();
    t_read_ack(4'd0, 16'h3C96);
    t_read_noack();
    t_busy_ignore();
    t_disabled();
    t_read_ack(4'd15, 16'h8001);
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule